// File: doc/BRIEF.md
# Dependence-Based Instruction Steering Unit

This block sits between rename and a row of in-order instruction buffers and picks, once per cycle, which buffer receives the next instruction. It follows one rule: place a consumer directly behind the instruction that produces its operand, so that dependent work stays in one buffer. If that is not possible, it places the consumer in an empty buffer of the producer's cluster, where operands forward without extra delay. If neither is possible, it stalls the instruction instead of sending it far away. Instructions whose operands are all available go to any empty buffer. The choice between clusters favours the one with more empty buffers.

To know where producers went, the unit keeps a table indexed by architectural register. Each entry holds a valid bit, the buffer the register's latest producer was sent to, and a flag that records that one consumer has already been placed behind that producer. Writeback notifications clear entries. The execution units report which buffers are empty and which are full. The unit registers these reports every cycle and marks the buffer it has just chosen as occupied.

Instructions arrive through a valid/ready handshake. An instruction is accepted in any cycle in which a target exists. While no target exists the unit raises a stall signal and keeps `in_ready` low, and the source retries the same instruction.

Top module: `steer_unit`

## Requirements
- R1: After reset every table entry is invalid, every buffer is treated as empty and none as full. An instruction presented in the first cycle after reset is accepted, and `out_valid` and `out_stall` are low while `in_valid` is low.
- R2: An instruction with no outstanding source goes to an empty buffer. Buffer IDs run from 0 to NUM_BUFS-1, and cluster k holds IDs k*CLUSTER_SIZE to k*CLUSTER_SIZE+CLUSTER_SIZE-1. The unit takes the cluster with the most empty buffers, the lower cluster on a tie, and the lowest-numbered empty buffer in that cluster.
- R3: With exactly one outstanding source whose flag is clear and whose producer buffer is not full, the instruction goes to the producer's buffer and the flag for that source register is set.
- R4: With exactly one outstanding source whose flag is already set, the instruction goes to the lowest-numbered empty buffer in the producer's cluster.
- R5: A producer buffer marked full is never chosen. The consumer then goes to the lowest-numbered empty buffer in the producer's cluster, as in R4.
- R6: With two outstanding sources the order of tries is fixed: the first source's producer buffer, then the second source's producer buffer, then the lowest empty buffer in the first producer's cluster, then the lowest empty buffer in the second producer's cluster.
- R7: When no allowed target exists, `out_stall` is high and `in_ready` and `out_valid` are low. A held instruction is accepted as soon as a suitable buffer is reported empty or its producer writes back.
- R8: A writeback makes its register's entry invalid, so later readers of that register count it as available. A writeback of a source register in the same cycle as the lookup already counts that source as available.
- R9: Every accepted instruction with `dst_en` set overwrites its destination register's entry with the chosen buffer and a clear flag. This takes priority over a flag set or a writeback to the same register in that cycle.
- R10: Decisions use the empty and full reports registered at the previous clock edge. The buffer chosen in a cycle is treated as non-empty in the next cycle, whatever the report said.
- R11: `out_buf` names the chosen buffer in any cycle with `out_valid` high. `out_valid` is `in_valid` and a target found, and `out_stall` is `in_valid` and no target found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | A target exists for the presented instruction |
| src_a_en | input | 1 | First source operand is used |
| src_a_reg | input | $clog2(NUM_REGS) | First source register |
| src_b_en | input | 1 | Second source operand is used |
| src_b_reg | input | $clog2(NUM_REGS) | Second source register |
| dst_en | input | 1 | Instruction writes a register |
| dst_reg | input | $clog2(NUM_REGS) | Destination register |
| wb_valid | input | 1 | A register value is written back this cycle |
| wb_reg | input | $clog2(NUM_REGS) | Register being written back |
| fb_empty | input | NUM_BUFS | Per-buffer empty report from the execution units |
| fb_full | input | NUM_BUFS | Per-buffer full report from the execution units |
| out_valid | output | 1 | Instruction accepted and steered this cycle |
| out_buf | output | $clog2(NUM_BUFS) | Chosen buffer ID |
| out_stall | output | 1 | Instruction presented but no target allowed |

## Verification
The assertions check on every cycle that some properties of each decision hold. A free or cluster placement always lands on a buffer marked empty, and a placement behind a producer never lands on a full buffer. A cluster fallback stays inside an outstanding producer's cluster. A claimed buffer reads as non-empty in the next cycle. An instruction with nothing outstanding is never refused while an empty buffer exists. The tie-break order, the exact priority among the two producers and the cluster fallbacks, the flag set after the first consumer, the destination overwrite and the timing of writeback bypass all depend on what happened earlier in the sequence. Only the bench's ordered scenarios show these, with expected buffer IDs worked out per step.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // How a steering decision was reached in the current cycle.
    typedef enum logic [1:0] {
        HOW_STALL   = 2'd0,
        HOW_FREE    = 2'd1,
        HOW_BEHIND  = 2'd2,
        HOW_CLUSTER = 2'd3
    } steer_how_e;

endpackage

// File: rtl/steer_prod_table.sv
module steer_prod_table #(
    parameter int NUM_REGS = 32,
    parameter int NUM_BUFS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_reg,
    output logic                        rd_a_valid,
    output logic                        rd_a_flag,
    output logic [$clog2(NUM_BUFS)-1:0] rd_a_buf,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_reg,
    output logic                        rd_b_valid,
    output logic                        rd_b_flag,
    output logic [$clog2(NUM_BUFS)-1:0] rd_b_buf,
    input  logic                        set_flag_a,
    input  logic                        set_flag_b,
    input  logic                        alloc_en,
    input  logic [$clog2(NUM_REGS)-1:0] alloc_reg,
    input  logic [$clog2(NUM_BUFS)-1:0] alloc_buf,
    input  logic                        wb_en,
    input  logic [$clog2(NUM_REGS)-1:0] wb_reg
);
    localparam int BW = $clog2(NUM_BUFS);

    typedef struct packed {
        logic          valid;
        logic          flag;
        logic [BW-1:0] bid;
    } ent_t;

    ent_t tab_q [NUM_REGS];
    ent_t tab_d [NUM_REGS];

    assign rd_a_valid = tab_q[rd_a_reg].valid;
    assign rd_a_flag  = tab_q[rd_a_reg].flag;
    assign rd_a_buf   = tab_q[rd_a_reg].bid;
    assign rd_b_valid = tab_q[rd_b_reg].valid;
    assign rd_b_flag  = tab_q[rd_b_reg].flag;
    assign rd_b_buf   = tab_q[rd_b_reg].bid;

    // Later statements win: writeback, then flag marks, then the new producer.
    always_comb begin
        tab_d = tab_q;
        if (wb_en) begin
            tab_d[wb_reg] = '0;
        end
        if (set_flag_a) begin
            tab_d[rd_a_reg].flag = 1'b1;
        end
        if (set_flag_b) begin
            tab_d[rd_b_reg].flag = 1'b1;
        end
        if (alloc_en) begin
            tab_d[alloc_reg] = '{valid: 1'b1, flag: 1'b0, bid: alloc_buf};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '{default: '0};
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/steer_pick.sv
module steer_pick #(
    parameter int NUM_BUFS     = 8,
    parameter int CLUSTER_SIZE = 4
) (
    input  logic [NUM_BUFS-1:0]                                    empty_vec,
    output logic [NUM_BUFS/CLUSTER_SIZE-1:0]                       clu_any,
    output logic [NUM_BUFS/CLUSTER_SIZE-1:0][$clog2(NUM_BUFS)-1:0] clu_low,
    output logic                                                   best_any,
    output logic [$clog2(NUM_BUFS)-1:0]                            best_bid
);
    localparam int BW   = $clog2(NUM_BUFS);
    localparam int NC   = NUM_BUFS / CLUSTER_SIZE;
    localparam int CIW  = (NC > 1) ? $clog2(NC) : 1;
    localparam int CNTW = $clog2(CLUSTER_SIZE + 1);

    logic [NC-1:0][CNTW-1:0] clu_cnt;

    for (genvar c = 0; c < NC; c++) begin : g_clu
        logic [CLUSTER_SIZE-1:0] slice;
        logic [BW-1:0]           low;
        logic [CNTW-1:0]         cnt;

        assign slice = empty_vec[c*CLUSTER_SIZE +: CLUSTER_SIZE];

        always_comb begin
            low = '0;
            cnt = '0;
            for (int k = CLUSTER_SIZE - 1; k >= 0; k--) begin
                if (slice[k]) begin
                    low = BW'(c * CLUSTER_SIZE + k);
                end
            end
            for (int k = 0; k < CLUSTER_SIZE; k++) begin
                cnt = cnt + CNTW'(slice[k]);
            end
        end

        assign clu_any[c] = |slice;
        assign clu_low[c] = low;
        assign clu_cnt[c] = cnt;
    end

    logic [CIW-1:0]  best_idx;
    logic [CNTW-1:0] best_cnt;

    // Strictly greater keeps the lower cluster on a tie.
    always_comb begin
        best_idx = '0;
        best_cnt = clu_cnt[0];
        for (int c = 1; c < NC; c++) begin
            if (clu_cnt[c] > best_cnt) begin
                best_idx = CIW'(c);
                best_cnt = clu_cnt[c];
            end
        end
    end

    assign best_any = |empty_vec;
    assign best_bid = clu_low[best_idx];

endmodule

// File: rtl/steer_unit.sv
module steer_unit
    import steer_pkg::*;
#(
    parameter int NUM_REGS     = 32,
    parameter int NUM_BUFS     = 8,
    parameter int CLUSTER_SIZE = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        src_a_en,
    input  logic [$clog2(NUM_REGS)-1:0] src_a_reg,
    input  logic                        src_b_en,
    input  logic [$clog2(NUM_REGS)-1:0] src_b_reg,
    input  logic                        dst_en,
    input  logic [$clog2(NUM_REGS)-1:0] dst_reg,
    input  logic                        wb_valid,
    input  logic [$clog2(NUM_REGS)-1:0] wb_reg,
    input  logic [NUM_BUFS-1:0]         fb_empty,
    input  logic [NUM_BUFS-1:0]         fb_full,
    output logic                        out_valid,
    output logic [$clog2(NUM_BUFS)-1:0] out_buf,
    output logic                        out_stall
);
    localparam int BW  = $clog2(NUM_BUFS);
    localparam int NC  = NUM_BUFS / CLUSTER_SIZE;
    localparam int CIW = (NC > 1) ? $clog2(NC) : 1;

    typedef struct packed {
        logic [NUM_BUFS-1:0] empty;
        logic [NUM_BUFS-1:0] full;
    } st_t;

    st_t st_q, st_d;

    function automatic logic [CIW-1:0] clu_of(input logic [BW-1:0] bid);
        return CIW'(int'(bid) / CLUSTER_SIZE);
    endfunction

    logic          a_valid, a_flag, b_valid, b_flag;
    logic [BW-1:0] a_buf, b_buf;
    logic          a_out, b_out, a_ok, b_ok;
    logic          x_ok;
    logic [BW-1:0] x_buf;
    logic          set_a, set_b, found, fire;
    logic [BW-1:0] pick;
    steer_how_e    how;

    logic [NC-1:0]         clu_any;
    logic [NC-1:0][BW-1:0] clu_low;
    logic                  best_any;
    logic [BW-1:0]         best_bid;

    steer_prod_table #(.NUM_REGS(NUM_REGS), .NUM_BUFS(NUM_BUFS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_reg   (src_a_reg),
        .rd_a_valid (a_valid),
        .rd_a_flag  (a_flag),
        .rd_a_buf   (a_buf),
        .rd_b_reg   (src_b_reg),
        .rd_b_valid (b_valid),
        .rd_b_flag  (b_flag),
        .rd_b_buf   (b_buf),
        .set_flag_a (fire && set_a),
        .set_flag_b (fire && set_b),
        .alloc_en   (fire && dst_en),
        .alloc_reg  (dst_reg),
        .alloc_buf  (pick),
        .wb_en      (wb_valid),
        .wb_reg     (wb_reg)
    );

    steer_pick #(.NUM_BUFS(NUM_BUFS), .CLUSTER_SIZE(CLUSTER_SIZE)) u_pick (
        .empty_vec (st_q.empty),
        .clu_any   (clu_any),
        .clu_low   (clu_low),
        .best_any  (best_any),
        .best_bid  (best_bid)
    );

    // A source is outstanding if its producer is tracked and not being written back now.
    assign a_out = src_a_en && a_valid && !(wb_valid && (wb_reg == src_a_reg));
    assign b_out = src_b_en && b_valid && !(wb_valid && (wb_reg == src_b_reg));
    assign a_ok  = a_out && !a_flag && !st_q.full[a_buf];
    assign b_ok  = b_out && !b_flag && !st_q.full[b_buf];

    always_comb begin
        how   = HOW_STALL;
        pick  = '0;
        set_a = 1'b0;
        set_b = 1'b0;
        x_ok  = a_out ? a_ok : b_ok;
        x_buf = a_out ? a_buf : b_buf;
        if (!a_out && !b_out) begin
            if (best_any) begin
                how  = HOW_FREE;
                pick = best_bid;
            end
        end else if (a_out && b_out) begin
            if (a_ok) begin
                how   = HOW_BEHIND;
                pick  = a_buf;
                set_a = 1'b1;
            end else if (b_ok) begin
                how   = HOW_BEHIND;
                pick  = b_buf;
                set_b = 1'b1;
            end else if (clu_any[clu_of(a_buf)]) begin
                how  = HOW_CLUSTER;
                pick = clu_low[clu_of(a_buf)];
            end else if (clu_any[clu_of(b_buf)]) begin
                how  = HOW_CLUSTER;
                pick = clu_low[clu_of(b_buf)];
            end
        end else begin
            if (x_ok) begin
                how   = HOW_BEHIND;
                pick  = x_buf;
                set_a = a_out;
                set_b = !a_out;
            end else if (clu_any[clu_of(x_buf)]) begin
                how  = HOW_CLUSTER;
                pick = clu_low[clu_of(x_buf)];
            end
        end
        found = (how != HOW_STALL);
        fire  = in_valid && found;

        st_d.empty = fb_empty & ~(fire ? (NUM_BUFS'(1) << pick) : '0);
        st_d.full  = fb_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.empty <= '1;
            st_q.full  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = found;
    assign out_valid = fire;
    assign out_buf   = pick;
    assign out_stall = in_valid && !found;

endmodule

// File: rtl/steer_unit_chk.sv
module steer_unit_chk
    import steer_pkg::*;
#(
    parameter int NUM_BUFS     = 8,
    parameter int CLUSTER_SIZE = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        out_valid,
    input logic [$clog2(NUM_BUFS)-1:0] out_buf,
    input steer_how_e                  how,
    input logic [NUM_BUFS-1:0]         empty_q,
    input logic [NUM_BUFS-1:0]         full_q,
    input logic                        a_out,
    input logic                        b_out,
    input logic [$clog2(NUM_BUFS)-1:0] a_buf,
    input logic [$clog2(NUM_BUFS)-1:0] b_buf
);
    function automatic int clu(input logic [$clog2(NUM_BUFS)-1:0] bid);
        return int'(bid) / CLUSTER_SIZE;
    endfunction

    assert_free_target_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (how != HOW_BEHIND) |-> empty_q[out_buf]);

    assert_behind_has_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (how == HOW_BEHIND) |-> !full_q[out_buf]);

    assert_cluster_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (how == HOW_CLUSTER) |->
            ((a_out && clu(out_buf) == clu(a_buf)) || (b_out && clu(out_buf) == clu(b_buf))));

    assert_claim_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !empty_q[$past(out_buf)]);

    assert_ready_free_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !a_out && !b_out && (|empty_q) |-> out_valid);

endmodule

bind steer_unit steer_unit_chk #(.NUM_BUFS(NUM_BUFS), .CLUSTER_SIZE(CLUSTER_SIZE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_buf   (out_buf),
    .how       (how),
    .empty_q   (st_q.empty),
    .full_q    (st_q.full),
    .a_out     (a_out),
    .b_out     (b_out),
    .a_buf     (a_buf),
    .b_buf     (b_buf)
);

// File: tb/steer_unit_test.sv
`timescale 1ns/1ps
module steer_unit_test;
    localparam int NUM_REGS = 32;
    localparam int NUM_BUFS = 8;
    localparam int RW = $clog2(NUM_REGS);
    localparam int BW = $clog2(NUM_BUFS);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic          src_a_en, src_b_en, dst_en;
    logic [RW-1:0] src_a_reg, src_b_reg, dst_reg;
    logic          wb_valid;
    logic [RW-1:0] wb_reg;
    logic [NUM_BUFS-1:0] fb_empty, fb_full;
    logic          out_valid;
    logic [BW-1:0] out_buf;
    logic          out_stall;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        bit    ok;
        int    bid;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    steer_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a_en(src_a_en), .src_a_reg(src_a_reg),
        .src_b_en(src_b_en), .src_b_reg(src_b_reg),
        .dst_en(dst_en), .dst_reg(dst_reg),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .fb_empty(fb_empty), .fb_full(fb_full),
        .out_valid(out_valid), .out_buf(out_buf), .out_stall(out_stall)
    );

    task automatic check(input bit cond, input string tag, input string act, input string exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Driver: presents one instruction for one cycle and queues the expected result.
    task automatic issue(input bit ae, input int a, input bit be, input int b, input int d,
                         input bit ok, input int bid, input string tag);
        exp_t e;
        in_valid  = 1'b1;
        src_a_en  = ae;
        src_a_reg = RW'(a);
        src_b_en  = be;
        src_b_reg = RW'(b);
        dst_en    = 1'b1;
        dst_reg   = RW'(d);
        e.ok = ok; e.bid = bid; e.tag = tag;
        sb_q.push_back(e);
        if (ok) fb_empty[bid] = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        wb_valid = 1'b0;
    endtask

    // Monitor: compares outputs against the scoreboard between edges.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (in_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11 unexpected", "instruction", "none queued");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(out_valid == e.ok && out_stall == !e.ok && in_ready == e.ok &&
                          (!e.ok || int'(out_buf) == e.bid), e.tag,
                          $sformatf("v=%0b s=%0b r=%0b buf=%0d", out_valid, out_stall, in_ready, out_buf),
                          $sformatf("v=%0b s=%0b r=%0b buf=%0d", e.ok, !e.ok, e.ok, e.bid));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", "finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0;
        src_a_en = 1'b0; src_b_en = 1'b0; dst_en = 1'b0;
        src_a_reg = '0; src_b_reg = '0; dst_reg = '0;
        wb_valid = 1'b0; wb_reg = '0;
        fb_empty = '1; fb_full = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid && !out_stall, "R1 idle outputs",
              $sformatf("v=%0b s=%0b", out_valid, out_stall), "v=0 s=0");
        check(in_ready, "R1 ready after reset", $sformatf("%0b", in_ready), "1");
        @(negedge clk);

        issue(0, 0, 0, 0, 1, 1, 0, "R1 R2 first free goes to buf0 on tie");
        issue(1, 1, 0, 0, 2, 1, 0, "R3 behind producer of r1");
        issue(1, 1, 0, 0, 3, 1, 1, "R4 flag set -> cluster0 lowest empty");
        issue(0, 0, 0, 0, 4, 1, 4, "R2 cluster with more empties");
        issue(1, 3, 1, 4, 5, 1, 1, "R6 first producer tried first");
        fb_full[1] = 1'b1;
        issue(1, 3, 1, 4, 6, 1, 4, "R6 second producer when first flagged");
        issue(1, 5, 0, 0, 7, 1, 2, "R5 full producer -> cluster empty");
        issue(1, 3, 1, 4, 8, 1, 3, "R6 first producer cluster fallback");
        issue(1, 1, 1, 4, 9, 1, 5, "R6 second producer cluster fallback");
        issue(1, 1, 0, 0, 10, 0, 0, "R7 stall with no target");
        fb_empty[2] = 1'b1;
        issue(1, 1, 0, 0, 10, 0, 0, "R10 report not seen until next edge");
        issue(1, 1, 0, 0, 10, 1, 2, "R7 R10 retry accepted after buffer drains");
        wb_valid = 1'b1; wb_reg = RW'(1);
        issue(1, 1, 0, 0, 11, 1, 6, "R8 same-cycle writeback counts as available");
        issue(1, 1, 0, 0, 12, 1, 7, "R8 invalid entry after writeback");
        fb_empty[4] = 1'b1; fb_empty[5] = 1'b1;
        issue(0, 0, 0, 0, 15, 0, 0, "R7 no empty buffer stalls free instruction");
        issue(0, 0, 0, 0, 2, 1, 4, "R2 R10 drained buffers visible");
        issue(1, 2, 0, 0, 13, 1, 4, "R9 consumer follows overwritten producer");
        issue(1, 2, 0, 0, 2, 1, 5, "R4 flagged producer -> cluster1 lowest");
        issue(1, 2, 0, 0, 14, 1, 5, "R9 overwrite cleared the flag");

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R11 scoreboard drained",
              $sformatf("%0d", sb_q.size()), "0");
        finish_run();
    end

endmodule